// File: doc/BRIEF.md
# Debug Register and Timestamp Unit

This block keeps the processor's four breakpoint address registers, the debug status register, the debug control register and a timestamp behind a single register port. A requester presents an index, a write enable and write data. The read data for the presented index appears combinationally in the same cycle. A write takes effect at the next rising clock edge.

The status and control registers come out of reset holding fixed patterns. Writes reach only their architecturally defined fields, and every other bit keeps its previous value. Two legacy indexes act as aliases of the status and control registers. The unit does not match breakpoints against addresses. If software arms any breakpoint enable in the control register, the block raises a sticky fault flag.

The timestamp is a free-running 64-bit cycle counter plus a stored offset. A timestamp read returns the offset plus the counter. A timestamp write stores the written value minus the counter, so the value read back keeps counting from the written value.

Top module: `dbgts_unit`

## Requirements
- R1: After reset, index 6 reads 64'h00000000FFFF0FF0, index 7 reads 64'h0000000000000400, indexes 0 to 3 read zero and `bp_fault` is 0.
- R2: Indexes 0 to 3 are breakpoint address registers. A write stores all 64 bits, which read back unchanged, and it has no other effect.
- R3: A write to index 6 (status) updates only bits 0 to 3, 13, 14 and 15, and all other bits keep their values.
- R4: A write to index 7 (control) updates only bits 0 to 7, 13 and 16 to 31, and all other bits keep their values.
- R5: Index 4 reads and writes exactly as index 6, and index 5 reads and writes exactly as index 7.
- R6: A control write that leaves any of bits 0 to 7 set makes `bp_fault` 1 from the next cycle onward. It stays 1 until reset, even if a later write clears those bits.
- R7: Index 8 is the timestamp. A read returns offset plus cycle count, and the count rises by one every clock after reset. After a write of value W, the read N cycles later returns W+N.
- R8: Timestamp arithmetic wraps modulo 2^64.
- R9: Indexes 9 to 15 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 4 | Register index (0-3 address, 4/5 aliases, 6 status, 7 control, 8 timestamp) |
| wr_en | input | 1 | Write strobe for the indexed register |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read data of the indexed register, same cycle |
| bp_fault | output | 1 | Sticky flag: a breakpoint enable was armed |

## Verification
Every cycle, the embedded assertions check these properties:
- the timestamp steps by one, or lands on the written value plus one after a write;
- the control register and the address bank hold when they are not written;
- the status register's fixed bits never move;
- the fault flag rises after an arming write and stays set.

Only the bench's scenarios can show that the values read back are correct for mixed sequences, because those checks compare against an independent register model. This covers the alias behaviour, the field masks applied to random data, offset wrap-around and the silence of unused indexes.

// File: rtl/dbgts_pkg.sv
package dbgts_pkg;
  localparam int XLEN  = 64;
  localparam int IDX_W = 4;
  localparam int N_BP  = 4;

  localparam logic [XLEN-1:0] STAT_WMASK = 64'h0000_0000_0000_E00F;
  localparam logic [XLEN-1:0] STAT_RESET = 64'h0000_0000_FFFF_0FF0;
  localparam logic [XLEN-1:0] CTRL_WMASK = 64'h0000_0000_FFFF_20FF;
  localparam logic [XLEN-1:0] CTRL_RESET = 64'h0000_0000_0000_0400;
  localparam int ARM_BITS = 2 * N_BP;

  localparam logic [IDX_W-1:0] IX_STAT_ALIAS = 4'd4;
  localparam logic [IDX_W-1:0] IX_CTRL_ALIAS = 4'd5;
  localparam logic [IDX_W-1:0] IX_STAT       = 4'd6;
  localparam logic [IDX_W-1:0] IX_CTRL       = 4'd7;
  localparam logic [IDX_W-1:0] IX_TIME       = 4'd8;

  typedef struct packed {
    logic [N_BP-1:0] bp;
    logic            stat;
    logic            ctrl;
    logic            tstamp;
    logic            none;
  } sel_t;

  // keep unmasked bits of old, take masked bits of new
  function automatic logic [XLEN-1:0] field_merge(
      input logic [XLEN-1:0] old_v, input logic [XLEN-1:0] new_v,
      input logic [XLEN-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  function automatic logic arm_seen(input logic [XLEN-1:0] ctrl_v);
    return |ctrl_v[ARM_BITS-1:0];
  endfunction

  function automatic logic [XLEN-1:0] ts_view(
      input logic [XLEN-1:0] off, input logic [XLEN-1:0] cnt);
    return off + cnt;
  endfunction

  function automatic logic [XLEN-1:0] ts_rebase(
      input logic [XLEN-1:0] wval, input logic [XLEN-1:0] cnt);
    return wval - cnt;
  endfunction
endpackage

// File: rtl/dbg_index_decode.sv
module dbg_index_decode
  import dbgts_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output sel_t             sel
);
  always_comb begin
    sel        = '0;
    sel.stat   = (idx == IX_STAT) || (idx == IX_STAT_ALIAS);
    sel.ctrl   = (idx == IX_CTRL) || (idx == IX_CTRL_ALIAS);
    sel.tstamp = (idx == IX_TIME);
    for (int i = 0; i < N_BP; i++) begin
      sel.bp[i] = (idx == IDX_W'(i));
    end
    sel.none = ~(|sel.bp | sel.stat | sel.ctrl | sel.tstamp);
  end

  always_comb begin
    AST_SEL_ONEHOT: assert ($onehot({sel.bp, sel.stat, sel.ctrl, sel.tstamp, sel.none})); // R5
  end
endmodule

// File: rtl/dbg_addr_bank.sv
module dbg_addr_bank
  import dbgts_pkg::*;
#(
  parameter int NUM = N_BP
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM-1:0]        wr_hit,
  input  logic [XLEN-1:0]       wdata,
  output logic [NUM-1:0][XLEN-1:0] addr_q
);
  for (genvar g = 0; g < NUM; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         addr_q[g] <= '0;
      else if (wr_hit[g]) addr_q[g] <= wdata;
    end

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[g] |=> $stable(addr_q[g])); // R2
    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[g] |=> addr_q[g] == $past(wdata)); // R2
  end
endmodule

// File: rtl/dbg_stat_ctrl.sv
module dbg_stat_ctrl
  import dbgts_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stat,
  input  logic            wr_ctrl,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] stat_q,
  output logic [XLEN-1:0] ctrl_q,
  output logic            fault_q
);
  logic [XLEN-1:0] stat_next;
  logic [XLEN-1:0] ctrl_next;
  logic            arm_event;

  assign stat_next = field_merge(stat_q, wdata, STAT_WMASK);
  assign ctrl_next = field_merge(ctrl_q, wdata, CTRL_WMASK);
  assign arm_event = wr_ctrl & arm_seen(ctrl_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= STAT_RESET;
      ctrl_q  <= CTRL_RESET;
      fault_q <= 1'b0;
    end else begin
      if (wr_stat)   stat_q  <= stat_next;
      if (wr_ctrl)   ctrl_q  <= ctrl_next;
      if (arm_event) fault_q <= 1'b1;
    end
  end

  AST_STAT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(stat_q & ~STAT_WMASK)); // R3
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q)); // R4
  AST_FAULT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && (|wdata[ARM_BITS-1:0])) |=> fault_q); // R6
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> fault_q); // R6
endmodule

// File: rtl/dbg_ts_counter.sv
module dbg_ts_counter
  import dbgts_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ts_wr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] ts_value
);
  logic [XLEN-1:0] cyc_q;
  logic [XLEN-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      off_q <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      if (ts_wr) off_q <= ts_rebase(wdata, cyc_q);
    end
  end

  assign ts_value = ts_view(off_q, cyc_q);

  AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_wr |=> ts_value == $past(ts_value) + 1'b1); // R7
  AST_TS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ts_wr |=> ts_value == $past(wdata) + 1'b1); // R8
endmodule

// File: rtl/dbgts_unit.sv
module dbgts_unit
  import dbgts_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic             wr_en,
  input  logic [XLEN-1:0]  wr_data,
  output logic [XLEN-1:0]  rd_data,
  output logic             bp_fault
);
  sel_t                      sel;
  logic [N_BP-1:0][XLEN-1:0] bp_addr;
  logic [XLEN-1:0]           stat_q;
  logic [XLEN-1:0]           ctrl_q;
  logic [XLEN-1:0]           ts_value;
  logic [N_BP-1:0]           bp_wr;
  logic                      stat_wr;
  logic                      ctrl_wr;
  logic                      ts_wr;

  dbg_index_decode u_dec (.idx(reg_idx), .sel(sel));

  assign bp_wr   = sel.bp & {N_BP{wr_en}};
  assign stat_wr = wr_en & sel.stat;
  assign ctrl_wr = wr_en & sel.ctrl;
  assign ts_wr   = wr_en & sel.tstamp;

  dbg_addr_bank #(.NUM(N_BP)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_hit(bp_wr), .wdata(wr_data), .addr_q(bp_addr));

  dbg_stat_ctrl u_sc (
    .clk(clk), .rst_n(rst_n), .wr_stat(stat_wr), .wr_ctrl(ctrl_wr),
    .wdata(wr_data), .stat_q(stat_q), .ctrl_q(ctrl_q), .fault_q(bp_fault));

  dbg_ts_counter u_ts (
    .clk(clk), .rst_n(rst_n), .ts_wr(ts_wr), .wdata(wr_data), .ts_value(ts_value));

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_BP; i++) begin
      if (sel.bp[i]) rd_data = bp_addr[i];
    end
    if (sel.stat)   rd_data = stat_q;
    if (sel.ctrl)   rd_data = ctrl_q;
    if (sel.tstamp) rd_data = ts_value;
  end

  AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sel.none |-> rd_data == '0); // R9
endmodule

// File: tb/dbgts_unit_bench.sv
module dbgts_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        bp_fault;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [63:0] m_bp [4];
  logic [63:0] m_stat, m_ctrl, m_off, m_cyc;
  bit          m_fault;

  always #10 clk = ~clk;

  dbgts_unit u_dbgts_unit (.clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .bp_fault(bp_fault));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_cyc <= '0;
    else        m_cyc <= m_cyc + 64'd1;

  // writable-bit masks built from bit lists
  function automatic logic [63:0] bits_stat();
    logic [63:0] m = '0;
    for (int b = 0; b < 4; b++) m[b] = 1'b1;
    m[13] = 1'b1; m[14] = 1'b1; m[15] = 1'b1;
    return m;
  endfunction
  function automatic logic [63:0] bits_ctrl();
    logic [63:0] m = '0;
    for (int b = 0; b < 8; b++) m[b] = 1'b1;
    m[13] = 1'b1;
    for (int b = 16; b < 32; b++) m[b] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] model_read(input logic [3:0] i);
    case (i)
      4'd0, 4'd1, 4'd2, 4'd3: return m_bp[i[1:0]];
      4'd4, 4'd6: return m_stat;
      4'd5, 4'd7: return m_ctrl;
      4'd8:       return m_off + m_cyc;
      default:    return 64'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [63:0] d);
    logic [63:0] mk;
    @(negedge clk);
    reg_idx = i; wr_en = 1'b1; wr_data = d;
    case (i)
      4'd0, 4'd1, 4'd2, 4'd3: m_bp[i[1:0]] = d;
      4'd4, 4'd6: begin mk = bits_stat(); m_stat = (m_stat & ~mk) | (d & mk); end
      4'd5, 4'd7: begin
        mk = bits_ctrl(); m_ctrl = (m_ctrl & ~mk) | (d & mk);
        if (m_ctrl[7:0] != 8'd0) m_fault = 1'b1;
      end
      4'd8: m_off = d - m_cyc;
      default: ;
    endcase
  endtask

  task automatic rd(input string req, input logic [3:0] i);
    @(negedge clk);
    wr_en = 1'b0; reg_idx = i;
    #2;
    check(req, rd_data, model_read(i));
  endtask

  task automatic chk_fault(input string req);
    @(negedge clk);
    wr_en = 1'b0;
    #2;
    check(req, {63'd0, bp_fault}, {63'd0, m_fault});
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0]  ri;
    logic [63:0] rdv;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4; k++) m_bp[k] = '0;
    m_stat = 64'h0000_0000_FFFF_0FF0;
    m_ctrl = 64'h0000_0000_0000_0400;
    m_off = '0; m_fault = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd("R1 stat", 4'd6);
    rd("R1 ctrl", 4'd7);
    for (int k = 0; k < 4; k++) rd("R1 addr", 4'(k));
    chk_fault("R1 fault");
    // R7 timestamp counts from reset
    rd("R7 ts after reset", 4'd8);
    rd("R7 ts next cycle", 4'd8);

    // R2 address registers
    for (int k = 0; k < 4; k++) wr(4'(k), {$urandom, $urandom});
    for (int k = 0; k < 4; k++) rd("R2 addr readback", 4'(k));

    // R3 status field mask, R5 alias
    wr(4'd6, 64'hFFFF_FFFF_FFFF_FFFF);
    rd("R3 stat all ones", 4'd6);
    wr(4'd4, 64'h0);
    rd("R5 stat via alias 4", 4'd6);
    rd("R5 alias 4 read", 4'd4);

    // R4 control field mask, R5 alias
    wr(4'd7, 64'hFFFF_FFFF_FFFF_DF00);
    rd("R4 ctrl", 4'd7);
    wr(4'd5, 64'h0000_0000_1234_0000);
    rd("R5 ctrl via alias 5", 4'd7);
    rd("R5 alias 5 read", 4'd5);
    chk_fault("R6 no fault yet");

    // R9 unused indexes
    for (int k = 9; k < 16; k++) wr(4'(k), 64'hDEAD_BEEF_CAFE_F00D);
    for (int k = 9; k < 16; k++) rd("R9 unused reads zero", 4'(k));
    for (int k = 0; k < 9; k++) rd("R9 regs unchanged", 4'(k));

    // R7 timestamp write then count
    wr(4'd8, 64'h0000_1000_0000_0000);
    rd("R7 ts W+1", 4'd8);
    rdv = rd_data;
    check("R7 ts direct", rdv, 64'h0000_1000_0000_0001);
    rd("R7 ts W+2", 4'd8);
    // R8 wrap
    wr(4'd8, 64'hFFFF_FFFF_FFFF_FFFE);
    rd("R8 ts wrap a", 4'd8);
    rd("R8 ts wrap b", 4'd8);
    check("R8 ts wrapped", rd_data, 64'd0);
    rd("R8 ts wrap c", 4'd8);

    // random mix, enables mostly clear
    for (int n = 0; n < 400; n++) begin
      ri = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 0) begin
        rdv = {$urandom, $urandom};
        if ((ri == 4'd5 || ri == 4'd7) && $urandom_range(0, 9) != 0) rdv[7:0] = 8'd0;
        if (n < 200 && (ri == 4'd5 || ri == 4'd7)) rdv[7:0] = 8'd0;
        wr(ri, rdv);
      end else begin
        rd("R2-R9 random read", ri);
      end
    end
    chk_fault("R6 fault matches model");

    // R6 arm then clear: stays set
    wr(4'd7, 64'h0000_0000_0000_0004);
    chk_fault("R6 fault set");
    wr(4'd7, 64'h0);
    chk_fault("R6 fault sticky");
    rd("R4 ctrl after clear", 4'd7);

    // R1 again after reset
    @(negedge clk); rst_n = 1'b0;
    for (int k = 0; k < 4; k++) m_bp[k] = '0;
    m_stat = 64'h0000_0000_FFFF_0FF0;
    m_ctrl = 64'h0000_0000_0000_0400;
    m_off = '0; m_fault = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk_fault("R1 fault cleared by reset");
    rd("R1 stat after reset", 4'd6);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule